// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a local controller and a parallel NOR flash. The controller gives it one operation per request: an opcode, a target byte address and a write data word, all taken with a one-cycle start strobe. The block then plays out the device's command protocol as a series of single bus cycles. Each command phase writes a fixed code to a fixed command offset. Two unlock writes come first, then the operation code, then any target-addressed cycle.

The device side is a plain memory-style master. A cycle holds its address, its data and one strobe until the device answers with ready. For the identification and query operations, the block also reads four result words back and keeps them in four 16-bit registers. The `cfg_wide` input selects a 16-bit device. In that mode a command offset is a word index and is doubled to form the byte address. In 8-bit mode the offset is added to the base address unchanged.

Top module: `nfl_cmd_sequencer`

## Requirements
- R1: After reset, `req_busy`, `req_done`, `req_reject`, `bus_we` and `bus_re` are low and all four identification words read zero.
- R2: A command address is `BASE_ADDR + 2*offset` when `cfg_wide` is 1 and `BASE_ADDR + offset` when it is 0. Every operation except read-array and query starts with two unlock writes: 0xAA to offset 0x555, then 0x55 to offset 0x2AA.
- R3: Opcode 2 (program) writes the unlock pair, then 0xA0 to offset 0x555, then `req_wdata` to `req_addr`. That is four writes in total.
- R4: Opcode 3 (sector erase) writes the unlock pair, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and finally 0x30 to `req_addr`.
- R5: Opcode 4 (chip erase) performs the same first five writes as R4, and its sixth write is 0x10 to offset 0x555.
- R6: Opcode 0 (read-array) is one write of 0xF0 to `BASE_ADDR`.
- R7: Opcode 1 (identify) writes the unlock pair and then 0x90 to 0x555. It then reads offsets 0x00, 0x01, 0x0E and 0x0F into `id_word0`..`id_word3`, in that order.
- R8: Opcode 5 (query) writes 0x98 to offset 0x55. It then reads offsets 0x10, 0x11, 0x12 and 0x13 into `id_word0`..`id_word3`.
- R9: At most one strobe is high at a time. While `bus_ready` is low, the active strobe, `bus_addr` and `bus_wdata` hold their values. The sequence advances only on a cycle with ready high.
- R10: `req_busy` rises in the cycle after an accepted start. A strobe is only ever high while busy. `req_done` is high for exactly one cycle, the cycle after the last handshake, and in that cycle `req_busy` is already low.
- R11: A start while busy is not accepted: `req_reject` is high in the next cycle and the running sequence is unchanged.
- R12: Opcodes 6 and 7 are ignored: no busy, no done, no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wide | input | 1 | 1: 16-bit device, offsets doubled; 0: 8-bit device |
| req_start | input | 1 | One-cycle operation request |
| req_op | input | 3 | Operation code |
| req_addr | input | AW | Target byte address for program and sector erase |
| req_wdata | input | DW | Word to program |
| req_busy | output | 1 | Operation in progress |
| req_reject | output | 1 | Pulse: the previous cycle's start was refused |
| req_done | output | 1 | Pulse: operation finished |
| id_word0 | output | 16 | Result word 0 (manufacturer code or first query word) |
| id_word1 | output | 16 | Result word 1 |
| id_word2 | output | 16 | Result word 2 |
| id_word3 | output | 16 | Result word 3 |
| bus_addr | output | AW | Device byte address |
| bus_wdata | output | DW | Device write data |
| bus_we | output | 1 | Write strobe, held until ready |
| bus_re | output | 1 | Read strobe, held until ready |
| bus_rdata | input | DW | Device read data, sampled with ready |
| bus_ready | input | 1 | Device completes the current cycle |

## Verification
A corrupted step index or opcode register shows up at the ports in the very next bus cycle. It appears as a wrong address or code in the ordered write log, or as a sequence that is longer or shorter than expected. The done pulse then lands on the wrong cycle count.

A fault in the ready gating shows within one clock. The strobe, address or data changes while ready is still low.

A slot error in the result capture only shows once the operation ends, when the four result words are compared with the device model's read data.

// File: rtl/nfl_pkg.sv
`timescale 1ns/1ps
package nfl_pkg;

   // operation codes on req_op
   localparam logic [2:0] OP_READ_ARRAY  = 3'd0;
   localparam logic [2:0] OP_IDENT       = 3'd1;
   localparam logic [2:0] OP_PROGRAM     = 3'd2;
   localparam logic [2:0] OP_SECT_ERASE  = 3'd3;
   localparam logic [2:0] OP_CHIP_ERASE  = 3'd4;
   localparam logic [2:0] OP_CFI_QUERY   = 3'd5;

   // command offsets (word index for wide devices)
   localparam logic [11:0] OFS_UNLOCK_A  = 12'h555;
   localparam logic [11:0] OFS_UNLOCK_B  = 12'h2AA;
   localparam logic [11:0] OFS_QUERY     = 12'h055;

   localparam int MAX_STEPS = 7;
   localparam int ID_SLOTS  = 4;

   typedef enum logic [1:0] {
      AS_CMD    = 2'd0,
      AS_TARGET = 2'd1,
      AS_BASE   = 2'd2
   } nfl_asel_e;

   typedef struct packed {
      logic        rd;        // read cycle instead of write
      nfl_asel_e   asel;      // address source
      logic [11:0] off;       // command offset when asel == AS_CMD
      logic        use_user;  // drive request data instead of cmd
      logic [7:0]  cmd;       // command code
      logic [1:0]  slot;      // result slot for reads
      logic        last;      // final step of the operation
   } nfl_step_t;

   function automatic logic op_known(input logic [2:0] op);
      return op <= OP_CFI_QUERY;
   endfunction

endpackage

// File: rtl/nfl_step_table.sv
`timescale 1ns/1ps
module nfl_step_table
   import nfl_pkg::*;
#(
   parameter int IW = 3
)(
   input  logic [2:0]    op,
   input  logic [IW-1:0] idx,
   output nfl_step_t     step
);

   function automatic nfl_step_t mk(input logic rd, input nfl_asel_e asel,
                                    input logic [11:0] off, input logic uu,
                                    input logic [7:0] cmd, input logic [1:0] slot,
                                    input logic last);
      nfl_step_t s;
      s.rd       = rd;
      s.asel     = asel;
      s.off      = off;
      s.use_user = uu;
      s.cmd      = cmd;
      s.slot     = slot;
      s.last     = last;
      return s;
   endfunction

   function automatic nfl_step_t wr_cmd(input logic [11:0] off, input logic [7:0] cmd,
                                        input logic last);
      return mk(1'b0, AS_CMD, off, 1'b0, cmd, 2'd0, last);
   endfunction

   function automatic nfl_step_t rd_cmd(input logic [11:0] off, input logic [1:0] slot,
                                        input logic last);
      return mk(1'b1, AS_CMD, off, 1'b0, 8'h00, slot, last);
   endfunction

   nfl_step_t safe_step;
   assign safe_step = mk(1'b0, AS_BASE, 12'h000, 1'b0, 8'hF0, 2'd0, 1'b1);

   always_comb begin
      step = safe_step;
      case (op)
         OP_READ_ARRAY: step = mk(1'b0, AS_BASE, 12'h000, 1'b0, 8'hF0, 2'd0, 1'b1);
         OP_CFI_QUERY: begin
            case (int'(idx))
               0:       step = wr_cmd(OFS_QUERY, 8'h98, 1'b0);
               1:       step = rd_cmd(12'h010, 2'd0, 1'b0);
               2:       step = rd_cmd(12'h011, 2'd1, 1'b0);
               3:       step = rd_cmd(12'h012, 2'd2, 1'b0);
               4:       step = rd_cmd(12'h013, 2'd3, 1'b1);
               default: step = safe_step;
            endcase
         end
         default: begin
            // operations with the unlock pair in front
            case (int'(idx))
               0: step = wr_cmd(OFS_UNLOCK_A, 8'hAA, 1'b0);
               1: step = wr_cmd(OFS_UNLOCK_B, 8'h55, 1'b0);
               default: begin
                  case (op)
                     OP_PROGRAM: begin
                        if (int'(idx) == 2) step = wr_cmd(OFS_UNLOCK_A, 8'hA0, 1'b0);
                        else                step = mk(1'b0, AS_TARGET, 12'h000, 1'b1,
                                                      8'h00, 2'd0, 1'b1);
                     end
                     OP_IDENT: begin
                        case (int'(idx))
                           2:       step = wr_cmd(OFS_UNLOCK_A, 8'h90, 1'b0);
                           3:       step = rd_cmd(12'h000, 2'd0, 1'b0);
                           4:       step = rd_cmd(12'h001, 2'd1, 1'b0);
                           5:       step = rd_cmd(12'h00E, 2'd2, 1'b0);
                           default: step = rd_cmd(12'h00F, 2'd3, 1'b1);
                        endcase
                     end
                     OP_SECT_ERASE, OP_CHIP_ERASE: begin
                        case (int'(idx))
                           2: step = wr_cmd(OFS_UNLOCK_A, 8'h80, 1'b0);
                           3: step = wr_cmd(OFS_UNLOCK_A, 8'hAA, 1'b0);
                           4: step = wr_cmd(OFS_UNLOCK_B, 8'h55, 1'b0);
                           default: begin
                              if (op == OP_SECT_ERASE)
                                 step = mk(1'b0, AS_TARGET, 12'h000, 1'b0, 8'h30, 2'd0, 1'b1);
                              else
                                 step = wr_cmd(OFS_UNLOCK_A, 8'h10, 1'b1);
                           end
                        endcase
                     end
                     default: step = safe_step;
                  endcase
               end
            endcase
         end
      endcase
   end

   // a read step never carries request data
   always_comb begin
      AST_READ_NO_USER: assert (!(step.rd && step.use_user)); // R7
   end

endmodule

// File: rtl/nfl_addr_former.sv
`timescale 1ns/1ps
module nfl_addr_former
   import nfl_pkg::*;
#(
   parameter int          AW        = 24,
   parameter int unsigned BASE_ADDR = 32'h0040_0000
)(
   input  nfl_asel_e     asel,
   input  logic [11:0]   off,
   input  logic          cfg_wide,
   input  logic [AW-1:0] tgt,
   output logic [AW-1:0] addr
);

   localparam logic [AW-1:0] BASE = AW'(BASE_ADDR);

   generate
      if (AW < 13 || AW > 32) begin : g_bad_aw
         $error("nfl_addr_former: AW must lie in 13..32");
      end
   endgenerate

   logic [AW-1:0] off_ext;
   logic [AW-1:0] off_bytes;

   assign off_ext   = AW'(off);
   assign off_bytes = cfg_wide ? (off_ext << 1) : off_ext;

   always_comb begin
      case (asel)
         AS_CMD:    addr = BASE + off_bytes;
         AS_TARGET: addr = tgt;
         default:   addr = BASE;
      endcase
   end

endmodule

// File: rtl/nfl_id_bank.sv
`timescale 1ns/1ps
module nfl_id_bank #(
   parameter int DW  = 16,
   parameter int NUM = 4,
   parameter int SW  = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap,
   input  logic [SW-1:0]   slot,
   input  logic [DW-1:0]   din,
   output logic [NUM*16-1:0] words
);

   logic [15:0] din16;

   generate
      if (DW == 16) begin : g_w16
         assign din16 = din;
      end else if (DW == 8) begin : g_w8
         assign din16 = {8'h00, din};
      end else begin : g_bad
         $error("nfl_id_bank: DW must be 8 or 16");
      end
      if ((1 << SW) < NUM) begin : g_bad_sw
         $error("nfl_id_bank: SW too narrow for NUM");
      end
   endgenerate

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      logic [15:0] w_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        w_q <= '0;
         else if (cap && int'(slot) == g)   w_q <= din16;
      end
      assign words[g*16 +: 16] = w_q;
   end

endmodule

// File: rtl/nfl_cmd_sequencer.sv
`timescale 1ns/1ps
module nfl_cmd_sequencer
   import nfl_pkg::*;
#(
   parameter int          AW        = 24,
   parameter int          DW        = 16,
   parameter int unsigned BASE_ADDR = 32'h0040_0000,
   parameter int          IW        = 3
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wide,
   input  logic          req_start,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_busy,
   output logic          req_reject,
   output logic          req_done,
   output logic [15:0]   id_word0,
   output logic [15:0]   id_word1,
   output logic [15:0]   id_word2,
   output logic [15:0]   id_word3,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   output logic          bus_we,
   output logic          bus_re,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ready
);

   localparam int NUM_ID = ID_SLOTS;
   localparam int SW     = $clog2(ID_SLOTS);

   generate
      if ((1 << IW) < MAX_STEPS) begin : g_bad_iw
         $error("nfl_cmd_sequencer: IW cannot count all steps");
      end
      if (DW != 8 && DW != 16) begin : g_bad_dw
         $error("nfl_cmd_sequencer: DW must be 8 or 16");
      end
   endgenerate

   logic          busy_q, done_q, rej_q;
   logic [2:0]    op_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] tgt_q;
   logic [DW-1:0] wd_q;
   nfl_step_t     step;
   logic          hs;
   logic          accept;
   logic [NUM_ID*16-1:0] id_words;

   nfl_step_table #(.IW(IW)) u_table (
      .op   (op_q),
      .idx  (idx_q),
      .step (step)
   );

   nfl_addr_former #(.AW(AW), .BASE_ADDR(BASE_ADDR)) u_addr (
      .asel     (step.asel),
      .off      (step.off),
      .cfg_wide (cfg_wide),
      .tgt      (tgt_q),
      .addr     (bus_addr)
   );

   assign hs        = busy_q && bus_ready;
   assign accept    = !busy_q && req_start && op_known(req_op);
   assign bus_we    = busy_q && !step.rd;
   assign bus_re    = busy_q && step.rd;
   assign bus_wdata = step.use_user ? wd_q : DW'(step.cmd);

   nfl_id_bank #(.DW(DW), .NUM(NUM_ID), .SW(SW)) u_ids (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (hs && step.rd),
      .slot  (step.slot),
      .din   (bus_rdata),
      .words (id_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         rej_q  <= 1'b0;
         op_q   <= OP_READ_ARRAY;
         idx_q  <= '0;
         tgt_q  <= '0;
         wd_q   <= '0;
      end else begin
         done_q <= 1'b0;
         rej_q  <= busy_q && req_start;
         if (accept) begin
            busy_q <= 1'b1;
            op_q   <= req_op;
            idx_q  <= '0;
            tgt_q  <= req_addr;
            wd_q   <= req_wdata;
         end else if (hs) begin
            if (step.last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               idx_q  <= '0;
            end else begin
               idx_q  <= idx_q + 1'b1;
            end
         end
      end
   end

   assign req_busy   = busy_q;
   assign req_done   = done_q;
   assign req_reject = rej_q;
   assign id_word0   = id_words[15:0];
   assign id_word1   = id_words[31:16];
   assign id_word2   = id_words[47:32];
   assign id_word3   = id_words[63:48];

   AST_ONE_STROBE:  assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && bus_re)); // R9
   AST_HOLD_WRITE:  assert property (@(posedge clk) disable iff (!rst_n)
                       (bus_we && !bus_ready) |=> (bus_we && $stable(bus_addr) && $stable(bus_wdata))); // R9
   AST_HOLD_READ:   assert property (@(posedge clk) disable iff (!rst_n)
                       (bus_re && !bus_ready) |=> (bus_re && $stable(bus_addr))); // R9
   AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) req_done |=> !req_done); // R10
   AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) req_done |-> !req_busy); // R10
   AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n)
                       (!req_busy && req_start && req_op <= 3'd5) |=> req_busy); // R10
   AST_REJECT:      assert property (@(posedge clk) disable iff (!rst_n)
                       (req_busy && req_start) |=> req_reject); // R11
   AST_BAD_OP_IGN:  assert property (@(posedge clk) disable iff (!rst_n)
                       (!req_busy && req_start && req_op > 3'd5) |=> (!req_busy && !bus_we && !bus_re)); // R12

endmodule

// File: tb/test_nfl_cmd_sequencer.sv
`timescale 1ns/1ps
module test_nfl_cmd_sequencer;

   localparam int          AW   = 24;
   localparam int          DW   = 16;
   localparam int unsigned BASE = 32'h0040_0000;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n;
   logic          cfg_wide;
   logic          req_start;
   logic [2:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic          req_busy, req_reject, req_done;
   logic [15:0]   id_word0, id_word1, id_word2, id_word3;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_we, bus_re;
   logic [DW-1:0] bus_rdata;
   logic          bus_ready;

   nfl_cmd_sequencer #(.AW(AW), .DW(DW), .BASE_ADDR(BASE)) i_nfl_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide),
      .req_start(req_start), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_busy(req_busy), .req_reject(req_reject), .req_done(req_done),
      .id_word0(id_word0), .id_word1(id_word1), .id_word2(id_word2), .id_word3(id_word3),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
      .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   int nchk  = 0;
   int nfail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
      return a[15:0] ^ 16'hC3A5;
   endfunction

   // ---------------- device model, evaluated every clock ----------------
   int                   lat;
   int                   wcnt;
   logic [AW+DW-1:0]     act_wr[$];
   logic [AW-1:0]        act_rd[$];
   bit                   pend;
   logic                 p_we;
   logic [AW-1:0]        p_addr;
   logic [DW-1:0]        p_data;

   always @(negedge clk) begin
      if (!rst_n) begin
         bus_ready = 1'b0;
         bus_rdata = '0;
         wcnt      = 0;
         pend      = 0;
      end else begin
         if (bus_we && bus_re) chk(0, "R9", "both strobes", 1, 0);
         if ((bus_we || bus_re) && !req_busy) chk(0, "R10", "strobe while idle", 1, 0);
         if (pend)
            chk(bus_we == p_we && (bus_we || bus_re) && bus_addr == p_addr &&
                (!p_we || bus_wdata == p_data), "R9", "cycle held without ready",
                {bus_addr, bus_wdata}, {p_addr, p_data});
         if (bus_we || bus_re) begin
            if (wcnt >= lat) begin
               bus_ready = 1'b1;
               wcnt      = 0;
               pend      = 0;
               if (bus_we) act_wr.push_back({bus_addr, bus_wdata});
               else begin
                  act_rd.push_back(bus_addr);
                  bus_rdata = rd_val(bus_addr);
               end
            end else begin
               bus_ready = 1'b0;
               wcnt++;
               pend   = 1;
               p_we   = bus_we;
               p_addr = bus_addr;
               p_data = bus_wdata;
            end
         end else begin
            bus_ready = 1'b0;
            pend      = 0;
            wcnt      = 0;
         end
      end
   end

   // ---------------- expected traffic ----------------
   logic [AW+DW-1:0] exp_wr[$];
   logic [AW-1:0]    exp_rd[$];

   function automatic logic [AW-1:0] caddr(input int off);
      return AW'(BASE + (cfg_wide ? off * 2 : off));
   endfunction

   task automatic ew(input int off, input int data);
      exp_wr.push_back({caddr(off), DW'(data)});
   endtask

   task automatic unlock_pair();
      ew('h555, 'hAA);
      ew('h2AA, 'h55);
   endtask

   task automatic run_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int nsteps, input string req, input int inject);
      int cnt;
      @(negedge clk);
      req_start = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_start = 1'b0;
      chk(req_busy == 1'b1, "R10", "busy after start", req_busy, 1);
      cnt = 1;
      while (!req_done && cnt < 400) begin
         @(negedge clk);
         cnt++;
         if (inject > 0 && cnt == inject) begin
            req_start = 1'b1; req_op = 3'd3; req_addr = 24'h05_0000;
         end else if (inject > 0 && cnt == inject + 1) begin
            req_start = 1'b0;
            chk(req_reject == 1'b1, "R11", "reject pulse", req_reject, 1);
         end
      end
      chk(cnt == nsteps * (lat + 1) + 1, "R10", "cycles to done", cnt, nsteps * (lat + 1) + 1);
      chk(!req_busy, "R10", "busy low with done", req_busy, 0);
      @(negedge clk);
      chk(!req_done, "R10", "done lasts one cycle", req_done, 0);
      chk(act_wr.size() == exp_wr.size(), req, "write count", act_wr.size(), exp_wr.size());
      for (int i = 0; i < exp_wr.size() && i < act_wr.size(); i++)
         chk(act_wr[i] == exp_wr[i], req, "write addr/data", act_wr[i], exp_wr[i]);
      chk(act_rd.size() == exp_rd.size(), req, "read count", act_rd.size(), exp_rd.size());
      for (int i = 0; i < exp_rd.size() && i < act_rd.size(); i++)
         chk(act_rd[i] == exp_rd[i], req, "read addr", act_rd[i], exp_rd[i]);
      act_wr.delete(); act_rd.delete(); exp_wr.delete(); exp_rd.delete();
   endtask

   task automatic check_ids(input string req, input int o0, input int o1, input int o2, input int o3);
      chk(id_word0 == rd_val(caddr(o0)), req, "id_word0", id_word0, rd_val(caddr(o0)));
      chk(id_word1 == rd_val(caddr(o1)), req, "id_word1", id_word1, rd_val(caddr(o1)));
      chk(id_word2 == rd_val(caddr(o2)), req, "id_word2", id_word2, rd_val(caddr(o2)));
      chk(id_word3 == rd_val(caddr(o3)), req, "id_word3", id_word3, rd_val(caddr(o3)));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      chk(0, "WATCHDOG", "run did not end", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cfg_wide = 1'b1; req_start = 1'b0; req_op = '0;
      req_addr = '0; req_wdata = '0; lat = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!req_busy && !req_done && !req_reject, "R1", "idle flags", {req_busy, req_done, req_reject}, 0);
      chk(!bus_we && !bus_re, "R1", "no strobe", {bus_we, bus_re}, 0);
      chk({id_word0, id_word1, id_word2, id_word3} == '0, "R1", "id words zero",
          {id_word0, id_word1, id_word2, id_word3}, 0);

      // R6 read-array
      exp_wr.push_back({AW'(BASE), DW'(16'h00F0)});
      run_op(3'd0, 24'h12_3456, 16'h0, 1, "R6", 0);

      // R3 / R2 program, wide device
      unlock_pair(); ew('h555, 'hA0);
      exp_wr.push_back({24'h01_2344, 16'hBEEF});
      run_op(3'd2, 24'h01_2344, 16'hBEEF, 4, "R3", 0);

      // R4 sector erase with slow device (R9 hold)
      lat = 2;
      unlock_pair(); ew('h555, 'h80); ew('h555, 'hAA); ew('h2AA, 'h55);
      exp_wr.push_back({24'h03_0000, 16'h0030});
      run_op(3'd3, 24'h03_0000, 16'h1234, 6, "R4", 0);

      // R5 chip erase
      lat = 0;
      unlock_pair(); ew('h555, 'h80); ew('h555, 'hAA); ew('h2AA, 'h55); ew('h555, 'h10);
      run_op(3'd4, 24'h00_0000, 16'h0, 6, "R5", 0);

      // R7 identify
      lat = 1;
      unlock_pair(); ew('h555, 'h90);
      exp_rd.push_back(caddr('h00)); exp_rd.push_back(caddr('h01));
      exp_rd.push_back(caddr('h0E)); exp_rd.push_back(caddr('h0F));
      run_op(3'd1, 24'h0, 16'h0, 7, "R7", 0);
      check_ids("R7", 'h00, 'h01, 'h0E, 'h0F);

      // R8 query
      lat = 0;
      ew('h055, 'h98);
      for (int k = 'h10; k <= 'h13; k++) exp_rd.push_back(caddr(k));
      run_op(3'd5, 24'h0, 16'h0, 5, "R8", 0);
      check_ids("R8", 'h10, 'h11, 'h12, 'h13);

      // R2 narrow device: offsets unshifted
      cfg_wide = 1'b0;
      unlock_pair(); ew('h555, 'hA0);
      exp_wr.push_back({24'h00_0100, 16'h00C7});
      run_op(3'd2, 24'h00_0100, 16'h00C7, 4, "R2", 0);
      unlock_pair(); ew('h555, 'h90);
      exp_rd.push_back(caddr('h00)); exp_rd.push_back(caddr('h01));
      exp_rd.push_back(caddr('h0E)); exp_rd.push_back(caddr('h0F));
      run_op(3'd1, 24'h0, 16'h0, 7, "R2", 0);
      check_ids("R2", 'h00, 'h01, 'h0E, 'h0F);
      cfg_wide = 1'b1;

      // R11 start while busy leaves the program sequence intact
      lat = 3;
      unlock_pair(); ew('h555, 'hA0);
      exp_wr.push_back({24'h00_7770, 16'h5A5A});
      run_op(3'd2, 24'h00_7770, 16'h5A5A, 4, "R11", 5);
      lat = 0;

      // R12 unused opcodes
      for (int c = 6; c <= 7; c++) begin
         @(negedge clk);
         req_start = 1'b1; req_op = 3'(c);
         @(negedge clk);
         req_start = 1'b0;
         for (int k = 0; k < 3; k++) begin
            chk(!req_busy && !req_done && !bus_we && !bus_re, "R12", "unused opcode idle",
                {req_busy, req_done, bus_we, bus_re}, 0);
            @(negedge clk);
         end
         chk(act_wr.size() == 0 && act_rd.size() == 0, "R12", "no bus traffic",
             act_wr.size() + act_rd.size(), 0);
      end

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule